// File: doc/BRIEF.md
# Thermal Threshold Throttle Controller

This block watches a 7-bit die temperature, given in whole degrees Celsius, and compares it with three programmable levels: an alarm level, a critical level and a trip level. Downstream logic gets a throttle gate that is active for a fraction of a fixed ten-cycle window. The fraction is set by the highest level reached. A policy bit selects 50% or 90% at the alarm level, and the critical level always gives 100%. When the trip level is reached, the block latches a fatal shutdown request toward the board controller. The request holds until reset.

Software reaches the block through a 64-bit register view with byte offsets. The threshold word holds the three levels, the two enables, the policy and two live status bits. A second word returns the sampled temperature. A third word is a capability word that reports whether automatic throttling is absent. A strap input sets that capability. While the strap is set, the block applies no throttling and reports both status bits as zero.

Top module: `thermThrottleTop`

## Requirements
- R1: After reset, throttleGate and fatalReq are 0. The threshold word at offset 0x08 reads alarm level 85 with its enable clear, critical level 95 with its enable clear, trip level 105 and policy 0.
- R2: A write to offset 0x08 stores the alarm level from bits [6:0] and its enable from bit 7. It stores the critical level from bits [14:8] and its enable from bit 15, the trip level from bits [30:24], and the policy from bit 44. All of these read back in the same positions.
- R3: Bit 32 of the threshold word reads 1 while the sampled temperature is equal to or greater than the alarm level and the alarm enable is set. Bit 33 behaves the same way for the critical level. Otherwise each bit reads 0.
- R4: At the alarm level and below the critical level, throttleGate is high for 9 of every 10 cycles when the policy is 0, and for 5 of every 10 cycles when the policy is 1.
- R5: At or above an enabled critical level, throttleGate is high on every cycle, whatever the policy.
- R6: A level whose enable is clear causes no throttling, even when the temperature is above it.
- R7: When the sampled temperature is equal to or greater than the trip level, fatalReq rises. It stays high when the temperature falls again, and only reset clears it.
- R8: Offset 0x10 returns the temperature sampled on the previous clock in bits [6:0], with all other bits 0.
- R9: Bit 0 of offset 0x20 reflects the noThrottle strap. While the strap is set, throttleGate stays 0 and status bits 32 and 33 read 0.
- R10: Writes to offset 0x10, to offset 0x20, to the status bits or to unused bits of the threshold word have no effect. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tempIn | input | 7 | Die temperature in degrees Celsius |
| noThrottle | input | 1 | Strap: automatic throttling not supported |
| regAddr | input | 6 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Register read data for regAddr (combinational) |
| throttleGate | output | 1 | Throttle enable pattern for downstream logic |
| fatalReq | output | 1 | Latched fatal shutdown request |

## Verification
The bench places the temperature exactly on each level and one degree below it. A design that used a strict comparison would miss the equal case, both in the status bits and in the gate. It counts gate pulses over ten consecutive cycles for each policy value and for the critical level. A swapped policy decode, or a wrong lower-priority level when both thresholds are crossed, changes the count. The bench lets the temperature fall after a trip, so a fatal request that follows the temperature instead of latching would drop. It also writes all ones to the read-only words and to unused bits. A decode that accepted those writes would change what reads back.

// File: rtl/thermPkg.sv
package thermPkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 64;
  localparam logic [ADDR_W-1:0] OFF_THRESH = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_TEMP   = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_CAP    = 6'h20;

  typedef enum logic [1:0] {
    LVL_NONE,
    LVL_HALF,
    LVL_NINETY,
    LVL_FULL
  } thrLevel_e;

  typedef struct packed {
    logic wrThresh;
    logic selThresh;
    logic selTemp;
    logic selCap;
  } regStrobe_t;
endpackage

// File: rtl/thermDatapath.sv
module thermDatapath
  import thermPkg::*;
#(
  parameter int TEMP_W = 7,
  parameter logic [TEMP_W-1:0] RST_ALARM = 85,
  parameter logic [TEMP_W-1:0] RST_CRIT  = 95,
  parameter logic [TEMP_W-1:0] RST_TRIP  = 105
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempIn,
  input  logic              noThrottle,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              hitAlarm,
  output logic              hitCrit,
  output logic              hitTrip,
  output logic              policy
);
  localparam int ALARM_LSB = 0;
  localparam int ALARM_EN  = 7;
  localparam int CRIT_LSB  = 8;
  localparam int CRIT_EN   = 15;
  localparam int TRIP_LSB  = 24;
  localparam int ST_ALARM  = 32;
  localparam int ST_CRIT   = 33;
  localparam int POL_BIT   = 44;

  logic [TEMP_W-1:0] tempReg, alarmLvl, critLvl, tripLvl;
  logic              alarmEn, critEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tempReg  <= '0;
      alarmLvl <= RST_ALARM;
      critLvl  <= RST_CRIT;
      tripLvl  <= RST_TRIP;
      alarmEn  <= 1'b0;
      critEn   <= 1'b0;
      policy   <= 1'b0;
    end else begin
      tempReg <= tempIn;
      if (strobe.wrThresh) begin
        alarmLvl <= wrData[ALARM_LSB +: TEMP_W];
        alarmEn  <= wrData[ALARM_EN];
        critLvl  <= wrData[CRIT_LSB +: TEMP_W];
        critEn   <= wrData[CRIT_EN];
        tripLvl  <= wrData[TRIP_LSB +: TEMP_W];
        policy   <= wrData[POL_BIT];
      end
    end
  end

  assign hitAlarm = alarmEn && !noThrottle && (tempReg >= alarmLvl);
  assign hitCrit  = critEn  && !noThrottle && (tempReg >= critLvl);
  assign hitTrip  = (tempReg >= tripLvl);

  always_comb begin
    rdData = '0;
    if (strobe.selThresh) begin
      rdData[ALARM_LSB +: TEMP_W] = alarmLvl;
      rdData[ALARM_EN]            = alarmEn;
      rdData[CRIT_LSB +: TEMP_W]  = critLvl;
      rdData[CRIT_EN]             = critEn;
      rdData[TRIP_LSB +: TEMP_W]  = tripLvl;
      rdData[ST_ALARM]            = hitAlarm;
      rdData[ST_CRIT]             = hitCrit;
      rdData[POL_BIT]             = policy;
    end else if (strobe.selTemp) begin
      rdData[TEMP_W-1:0] = tempReg;
    end else if (strobe.selCap) begin
      rdData[0] = noThrottle;
    end
  end

  // R10
  thresh_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrThresh |=> $stable({alarmLvl, alarmEn, critLvl, critEn, tripLvl, policy}));

  // R2
  thresh_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrThresh |=> tripLvl == $past(wrData[TRIP_LSB +: TEMP_W]));
endmodule

// File: rtl/thermControl.sv
module thermControl
  import thermPkg::*;
#(
  parameter int WINDOW    = 10,
  parameter int HALF_ON   = 5,
  parameter int NINETY_ON = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              hitAlarm,
  input  logic              hitCrit,
  input  logic              hitTrip,
  input  logic              policy,
  input  logic              noThrottle,
  output regStrobe_t        strobe,
  output logic              throttleGate,
  output logic              fatalReq
);
  localparam int CNT_W = $clog2(WINDOW);

  logic [CNT_W-1:0] winCnt;
  thrLevel_e        level;

  always_comb begin
    strobe.wrThresh  = regWrEn && (regAddr == OFF_THRESH);
    strobe.selThresh = (regAddr == OFF_THRESH);
    strobe.selTemp   = (regAddr == OFF_TEMP);
    strobe.selCap    = (regAddr == OFF_CAP);
  end

  always_comb begin
    if (hitCrit)                 level = LVL_FULL;
    else if (hitAlarm && policy) level = LVL_HALF;
    else if (hitAlarm)           level = LVL_NINETY;
    else                         level = LVL_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt       <= '0;
      throttleGate <= 1'b0;
      fatalReq     <= 1'b0;
    end else begin
      winCnt <= (winCnt == CNT_W'(WINDOW - 1)) ? '0 : winCnt + 1'b1;
      unique case (level)
        LVL_FULL:   throttleGate <= 1'b1;
        LVL_NINETY: throttleGate <= (winCnt < CNT_W'(NINETY_ON));
        LVL_HALF:   throttleGate <= (winCnt < CNT_W'(HALF_ON));
        default:    throttleGate <= 1'b0;
      endcase
      fatalReq <= fatalReq | hitTrip;
    end
  end

  // R5
  crit_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitCrit |=> throttleGate);

  // R7
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    fatalReq |=> fatalReq);

  // R9
  strap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    noThrottle |=> !throttleGate);

  // R4
  win_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    winCnt < CNT_W'(WINDOW));
endmodule

// File: rtl/thermThrottleTop.sv
module thermThrottleTop
  import thermPkg::*;
#(
  parameter int TEMP_W    = 7,
  parameter int WINDOW    = 10,
  parameter int HALF_ON   = 5,
  parameter int NINETY_ON = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempIn,
  input  logic              noThrottle,
  input  logic [5:0]        regAddr,
  input  logic              regWrEn,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  output logic              throttleGate,
  output logic              fatalReq
);
  regStrobe_t strobe;
  logic hitAlarm, hitCrit, hitTrip, policy;

  thermControl #(
    .WINDOW(WINDOW), .HALF_ON(HALF_ON), .NINETY_ON(NINETY_ON)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .hitAlarm(hitAlarm), .hitCrit(hitCrit), .hitTrip(hitTrip),
    .policy(policy), .noThrottle(noThrottle), .strobe(strobe),
    .throttleGate(throttleGate), .fatalReq(fatalReq)
  );

  thermDatapath #(.TEMP_W(TEMP_W)) u_dp (
    .clk(clk), .rstN(rstN), .tempIn(tempIn), .noThrottle(noThrottle),
    .strobe(strobe), .wrData(regWrData), .rdData(regRdData),
    .hitAlarm(hitAlarm), .hitCrit(hitCrit), .hitTrip(hitTrip),
    .policy(policy)
  );
endmodule

// File: tb/thermThrottleTop_bench.sv
module thermThrottleTop_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  tempIn = 7'd25;
  logic        noThrottle = 1'b0;
  logic [5:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        throttleGate, fatalReq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  thermThrottleTop u_thermThrottleTop (
    .clk(clk), .rstN(rstN), .tempIn(tempIn), .noThrottle(noThrottle),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .throttleGate(throttleGate), .fatalReq(fatalReq)
  );

  function automatic logic [63:0] mkThresh(input int a, input bit ae, input int c,
                                            input bit ce, input int t, input bit p);
    logic [63:0] w = '0;
    w[6:0] = 7'(a); w[7] = ae; w[14:8] = 7'(c); w[15] = ce;
    w[30:24] = 7'(t); w[44] = p;
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1 regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [63:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdData;
  endtask

  task automatic setTemp(input int t);
    @(negedge clk); tempIn = 7'(t);
    repeat (3) @(posedge clk);
  endtask

  task automatic duty(output int n);
    n = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); n += int'(throttleGate); end
  endtask

  task automatic tReset();
    logic [63:0] d;
    doReset();
    @(negedge clk);
    check("R1 gate", 64'(throttleGate), 0);
    check("R1 fatal", 64'(fatalReq), 0);
    regRead(6'h08, d);
    check("R1 thresh", d, mkThresh(85, 0, 95, 0, 105, 0));
  endtask

  task automatic tLayout();
    logic [63:0] d;
    regWrite(6'h08, mkThresh(33, 1, 77, 0, 120, 1));
    regRead(6'h08, d);
    check("R2 layout", d, mkThresh(33, 1, 77, 0, 120, 1));
  endtask

  task automatic tStatus();
    logic [63:0] d, base;
    base = mkThresh(40, 1, 60, 1, 100, 0);
    regWrite(6'h08, base);
    setTemp(39); regRead(6'h08, d); check("R3 below", d, base);
    setTemp(40); regRead(6'h08, d); check("R3 at alarm", d, base | (64'd1 << 32));
    setTemp(60); regRead(6'h08, d); check("R3 at crit", d, base | (64'd3 << 32));
    regWrite(6'h08, mkThresh(40, 0, 60, 0, 100, 0));
    regRead(6'h08, d); check("R3 disabled", d, mkThresh(40, 0, 60, 0, 100, 0));
  endtask

  task automatic tPolicy();
    int n;
    regWrite(6'h08, mkThresh(40, 1, 60, 1, 100, 0));
    setTemp(40); duty(n); check("R4 policy0", 64'(n), 9);
    regWrite(6'h08, mkThresh(40, 1, 60, 1, 100, 1));
    setTemp(50); duty(n); check("R4 policy1", 64'(n), 5);
    setTemp(39); duty(n); check("R4 below", 64'(n), 0);
  endtask

  task automatic tCrit();
    int n;
    regWrite(6'h08, mkThresh(40, 1, 60, 1, 100, 1));
    setTemp(60); duty(n); check("R5 crit p1", 64'(n), 10);
    regWrite(6'h08, mkThresh(40, 1, 60, 1, 100, 0));
    setTemp(70); duty(n); check("R5 crit p0", 64'(n), 10);
  endtask

  task automatic tDisabled();
    int n;
    regWrite(6'h08, mkThresh(40, 0, 60, 0, 100, 0));
    setTemp(80); duty(n); check("R6 none", 64'(n), 0);
    regWrite(6'h08, mkThresh(40, 1, 60, 0, 100, 1));
    setTemp(80); duty(n); check("R6 crit off", 64'(n), 5);
    setTemp(25);
  endtask

  task automatic tTempRead();
    logic [63:0] d;
    setTemp(77); regRead(6'h10, d); check("R8 temp", d, 64'd77);
    setTemp(3);  regRead(6'h10, d); check("R8 temp low", d, 64'd3);
  endtask

  task automatic tCap();
    logic [63:0] d;
    int n;
    regRead(6'h20, d); check("R9 cap0", d, 0);
    regWrite(6'h08, mkThresh(40, 1, 60, 1, 100, 0));
    @(negedge clk); noThrottle = 1'b1;
    setTemp(70);
    regRead(6'h20, d); check("R9 cap1", d, 1);
    regRead(6'h08, d); check("R9 status", d, mkThresh(40, 1, 60, 1, 100, 0));
    duty(n); check("R9 gate", 64'(n), 0);
    @(negedge clk); noThrottle = 1'b0;
    setTemp(25);
  endtask

  task automatic tReadOnly();
    logic [63:0] d;
    regWrite(6'h08, mkThresh(40, 1, 60, 1, 100, 0));
    setTemp(30);
    regWrite(6'h10, '1);
    regRead(6'h10, d); check("R10 temp ro", d, 64'd30);
    regWrite(6'h20, '1);
    regRead(6'h20, d); check("R10 cap ro", d, 0);
    regWrite(6'h08, ~mkThresh(127, 1, 127, 1, 127, 1) | mkThresh(41, 0, 61, 1, 101, 1));
    regRead(6'h08, d); check("R10 unused bits", d, mkThresh(41, 0, 61, 1, 101, 1));
    regWrite(6'h18, '1);
    regRead(6'h18, d); check("R10 unmapped", d, 0);
  endtask

  task automatic tTrip();
    regWrite(6'h08, mkThresh(40, 0, 60, 0, 100, 0));
    setTemp(99); check("R7 below trip", 64'(fatalReq), 0);
    setTemp(100); check("R7 at trip", 64'(fatalReq), 1);
    setTemp(20); check("R7 sticky", 64'(fatalReq), 1);
    doReset(); @(negedge clk);
    check("R7 reset clears", 64'(fatalReq), 0);
  endtask

  initial begin
    tReset();
    tLayout();
    tStatus();
    tPolicy();
    tCrit();
    tDisabled();
    tTempRead();
    tCap();
    tReadOnly();
    tTrip();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule